// File: doc/BRIEF.md
# Segment-to-Word Memory Address Adapter

This block sits between a user port that moves 128-bit segments and a memory whose data bus is 32 bits wide and whose addresses count 32-bit words. The user names a location with video coordinates: a pixel index within a line, a line number and the number of pixels per line. The block turns these into a segment index. It then scales that index by four onto the word-addressed bus and sends out four consecutive word accesses.

A write is split into four 32-bit beats, lowest word first. A short write, which carries fewer than four valid words, is still sent as four beats. The missing words are written as zero, so the next segment always starts on a four-word boundary. A read sends out four word reads and assembles the four returned words into one 128-bit result. The result is marked by a single-cycle valid pulse.

Coordinates, write data and word count are captured only in the cycle a command is accepted. While an access is in flight, the block reports busy and refuses new commands. A segment index past the end of memory raises an error pulse, and nothing is sent to the memory.

Top module: `seg_word_adapter`

## Requirements
- R1: For segment n, the four memory beats carry the word addresses 4n, 4n+1, 4n+2 and 4n+3, in that order. The low two bits of `mem_addr` hold the beat number 0 to 3, and the upper bits hold n.
- R2: During a write, beat k drives `wr_data` bits [32k+31:32k] on `mem_wdata`. The least significant word goes to 4n and the most significant word goes to 4n+3.
- R3: `wr_word_cnt` gives the number of valid words w. A value of 1 to 4 is used as given, and 0 or a value above 4 means 4. Beats k >= w drive zero data. Four beats are still issued, so the next command starts at a multiple of four.
- R4: The segment index equals `pix_idx + line_idx * pix_per_line`.
- R5: Coordinates, write data and word count are sampled only in the cycle a command is accepted. Changes to them at any other time have no effect on the access in flight.
- R6: While `mem_ready` is low, the current beat holds its address and data. A beat counts as done only on a clock edge where its strobe and `mem_ready` are both high.
- R7: `busy` rises in the cycle after acceptance. For a write it stays high until the fourth beat is done. For a read it stays high until the fourth word has returned. A command presented while `busy` is high is refused and causes no memory beats.
- R8: In a read, the k-th word returned with `mem_rvalid` is placed in `rd_data` bits [32k+31:32k]. `rd_valid` is a one-cycle pulse, raised in the same cycle `busy` falls.
- R9: The block has 4096 segments (memory bytes / 16). If the computed index is 4096 or more, `err` pulses for one cycle after the command. No beat is issued and `busy` stays low.
- R10: If `cmd_wr_en` and `cmd_rd_en` are both high in one cycle, the block performs only the write.
- R11: While `rst_n` is low at a clock edge, `busy`, `err`, `rd_valid`, `mem_wr` and `mem_rd` go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_wr_en | input | 1 | Write command strobe |
| cmd_rd_en | input | 1 | Read command strobe |
| pix_idx | input | 12 | Pixel index within the line |
| line_idx | input | 12 | Line number |
| pix_per_line | input | 12 | Pixels per line |
| wr_data | input | 128 | Segment write data |
| wr_word_cnt | input | 3 | Valid 32-bit words in the write |
| busy | output | 1 | Access in flight; new commands are refused |
| err | output | 1 | Out-of-range segment pulse |
| rd_valid | output | 1 | Read result valid pulse |
| rd_data | output | 128 | Assembled read segment |
| mem_addr | output | 14 | Word address |
| mem_wr | output | 1 | Word write strobe |
| mem_rd | output | 1 | Word read strobe |
| mem_wdata | output | 32 | Word write data |
| mem_ready | input | 1 | Memory accepts the current beat |
| mem_rdata | input | 32 | Returned read word |
| mem_rvalid | input | 1 | Returned read word valid |

## Verification
The bench checks the segment boundaries 0 and 4095, and the first index past the end (4096). An off-by-one range compare would either lose the last segment or issue beats past the memory. Writes of one and three words, and a word count of 0, are read back. A design that skipped the padding would shift every later segment off its four-word boundary, or would leave stale words behind. A ready signal that toggles every cycle catches a sequencer that advances without a handshake; such a design would drop beats or write data to the wrong address. Changing the coordinates during an access, sending a command while busy, and raising both strobes together catch a design that re-samples its inputs, restarts during an access, or issues reads alongside writes.

// File: rtl/seg_adapt_pkg.sv
// Shared definitions for the segment-to-word adapter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package seg_adapt_pkg;
    // Kind of access held by the sequencer.
    typedef enum logic {
        ACC_WRITE = 1'b0,
        ACC_READ  = 1'b1
    } acc_kind_e;
endpackage

// File: rtl/seg_addr_calc.sv
// Segment index calculator: index = pixel + line * pixels_per_line.
// Also decides whether that index falls inside the memory.
// Assumes SEG_AW <= PIX_W + LINE_W + 1 and NUM_SEGS fits that width.
module seg_addr_calc #(
    parameter int PIX_W    = 12,
    parameter int LINE_W   = 12,
    parameter int NUM_SEGS = 4096,
    parameter int SEG_AW   = 12
) (
    input  logic [PIX_W-1:0]  pix,
    input  logic [LINE_W-1:0] line,
    input  logic [PIX_W-1:0]  ppl,
    output logic [SEG_AW-1:0] seg,
    output logic              in_range
);
    localparam int SUM_W = PIX_W + LINE_W + 1;

    logic [SUM_W-1:0] full_idx;

    // Linear index from the coordinates, plus the range test against memory size.
    always_comb begin
        full_idx = SUM_W'(pix) + SUM_W'(line) * SUM_W'(ppl);
        in_range = (full_idx < SUM_W'(NUM_SEGS));
        seg      = full_idx[SEG_AW-1:0];
    end
endmodule

// File: rtl/beat_sequencer.sv
// Beat sequencer: captures one accepted command and sends out four word
// beats at {segment, beat}. Write beats carry one word each, and padded
// words are driven as zero. Assumes BEATS is a power of two, and that
// start_wr and start_rd are never high together.
module beat_sequencer
    import seg_adapt_pkg::*;
#(
    parameter int SEG_AW = 12,
    parameter int WORD_W = 32,
    parameter int BEATS  = 4,
    localparam int BEAT_W = $clog2(BEATS),
    localparam int CNT_W  = $clog2(BEATS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_wr,
    input  logic                          start_rd,
    input  logic [SEG_AW-1:0]             seg_in,
    input  logic [BEATS-1:0][WORD_W-1:0]  wdata_in,
    input  logic [CNT_W-1:0]              words_in,
    input  logic                          mem_ready,
    input  logic                          rd_last,
    output logic                          busy,
    output logic [SEG_AW+BEAT_W-1:0]      mem_addr,
    output logic                          mem_wr,
    output logic                          mem_rd,
    output logic [WORD_W-1:0]             mem_wdata
);
    logic                         busy_q;
    acc_kind_e                    kind_q;
    logic                         sent_all_q;
    logic [BEAT_W-1:0]            beat_q;
    logic [SEG_AW-1:0]            seg_q;
    logic [BEATS-1:0][WORD_W-1:0] data_q;
    logic [CNT_W-1:0]             words_q;
    logic                         issuing;

    assign issuing = busy_q && !sent_all_q;

    // Capture a command, step the beats on ready, and end the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            kind_q     <= ACC_WRITE;
            sent_all_q <= 1'b0;
            beat_q     <= '0;
            seg_q      <= '0;
            data_q     <= '0;
            words_q    <= '0;
        end else if (!busy_q) begin
            if (start_wr || start_rd) begin
                busy_q     <= 1'b1;
                kind_q     <= start_rd ? ACC_READ : ACC_WRITE;
                sent_all_q <= 1'b0;
                beat_q     <= '0;
                seg_q      <= seg_in;
                data_q     <= wdata_in;
                words_q    <= (words_in == '0 || words_in > CNT_W'(BEATS))
                              ? CNT_W'(BEATS) : words_in;
            end
        end else begin
            if (issuing && mem_ready) begin
                if (beat_q == BEAT_W'(BEATS - 1)) begin
                    sent_all_q <= 1'b1;
                    if (kind_q == ACC_WRITE) busy_q <= 1'b0;
                end else begin
                    beat_q <= beat_q + 1'b1;
                end
            end
            if (kind_q == ACC_READ && rd_last) busy_q <= 1'b0;
        end
    end

    // Drive the beat strobes, the scaled word address and the padded data.
    always_comb begin
        busy      = busy_q;
        mem_wr    = issuing && (kind_q == ACC_WRITE);
        mem_rd    = issuing && (kind_q == ACC_READ);
        mem_addr  = {seg_q, beat_q};
        mem_wdata = (CNT_W'(beat_q) < words_q) ? data_q[beat_q] : '0;
    end

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issuing && !mem_ready) |=> ((mem_wr || mem_rd) &&
            mem_addr == $past(mem_addr) && mem_wdata == $past(mem_wdata)));

    // R1
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issuing && mem_ready && beat_q != BEAT_W'(BEATS - 1))
            |=> (mem_addr == $past(mem_addr) + 1'b1));

    // R5
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(seg_q));
endmodule

// File: rtl/read_gather.sv
// Read gatherer: collects BEATS returned words in arrival order and
// presents them as one wide word with a one-cycle valid pulse.
// Assumes the memory returns words in the order they were requested.
module read_gather #(
    parameter int WORD_W = 32,
    parameter int BEATS  = 4,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     mem_rvalid,
    input  logic [WORD_W-1:0]        mem_rdata,
    output logic                     rd_last,
    output logic                     rd_valid,
    output logic [BEATS*WORD_W-1:0]  rd_data
);
    logic                         active_q;
    logic [BEAT_W-1:0]            cnt_q;
    logic [BEATS-1:0][WORD_W-1:0] buf_q;
    logic [BEATS-1:0][WORD_W-1:0] full_word;

    // The top word comes straight from the bus on the final return.
    for (genvar k = 0; k < BEATS; k++) begin : g_lane
        if (k == BEATS - 1) begin : g_top
            assign full_word[k] = mem_rdata;
        end else begin : g_low
            assign full_word[k] = buf_q[k];
        end
    end

    assign rd_last = active_q && mem_rvalid && (cnt_q == BEAT_W'(BEATS - 1));

    // Arm on a read start, store each returned word, and publish on the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            buf_q    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (start) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
            end else if (active_q && mem_rvalid) begin
                buf_q[cnt_q] <= mem_rdata;
                if (rd_last) begin
                    active_q <= 1'b0;
                    rd_valid <= 1'b1;
                    rd_data  <= full_word;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R8
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/seg_word_adapter.sv
// Top of the segment-to-word adapter. It accepts commands when idle,
// works out the segment from pixel coordinates, rejects indices outside
// memory, and hands the access to the sequencer and the read gatherer.
// Assumes one access at a time and a memory that returns reads in order.
module seg_word_adapter #(
    parameter int WORD_W    = 32,
    parameter int BEATS     = 4,
    parameter int MEM_BYTES = 65536,
    parameter int PIX_W     = 12,
    parameter int LINE_W    = 12,
    localparam int SEG_W    = WORD_W * BEATS,
    localparam int NUM_SEGS = MEM_BYTES / (SEG_W / 8),
    localparam int SEG_AW   = $clog2(NUM_SEGS),
    localparam int MADDR_W  = SEG_AW + $clog2(BEATS),
    localparam int CNT_W    = $clog2(BEATS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr_en,
    input  logic               cmd_rd_en,
    input  logic [PIX_W-1:0]   pix_idx,
    input  logic [LINE_W-1:0]  line_idx,
    input  logic [PIX_W-1:0]   pix_per_line,
    input  logic [SEG_W-1:0]   wr_data,
    input  logic [CNT_W-1:0]   wr_word_cnt,
    output logic               busy,
    output logic               err,
    output logic               rd_valid,
    output logic [SEG_W-1:0]   rd_data,
    output logic [MADDR_W-1:0] mem_addr,
    output logic               mem_wr,
    output logic               mem_rd,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic               mem_ready,
    input  logic [WORD_W-1:0]  mem_rdata,
    input  logic               mem_rvalid
);
    logic [SEG_AW-1:0] seg_idx;
    logic              in_range;
    logic              accept;
    logic              start_wr;
    logic              start_rd;
    logic              rd_last;

    seg_addr_calc #(
        .PIX_W(PIX_W), .LINE_W(LINE_W), .NUM_SEGS(NUM_SEGS), .SEG_AW(SEG_AW)
    ) calc_i (
        .pix(pix_idx), .line(line_idx), .ppl(pix_per_line),
        .seg(seg_idx), .in_range(in_range)
    );

    // Accept only when idle; a write wins over a read in the same cycle.
    always_comb begin
        accept   = !busy && (cmd_wr_en || cmd_rd_en);
        start_wr = accept && in_range && cmd_wr_en;
        start_rd = accept && in_range && cmd_rd_en && !cmd_wr_en;
    end

    // One-cycle error pulse for a command that points past the end of memory.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= accept && !in_range;
    end

    beat_sequencer #(
        .SEG_AW(SEG_AW), .WORD_W(WORD_W), .BEATS(BEATS)
    ) seq_i (
        .clk(clk), .rst_n(rst_n),
        .start_wr(start_wr), .start_rd(start_rd),
        .seg_in(seg_idx), .wdata_in(wr_data), .words_in(wr_word_cnt),
        .mem_ready(mem_ready), .rd_last(rd_last),
        .busy(busy), .mem_addr(mem_addr), .mem_wr(mem_wr),
        .mem_rd(mem_rd), .mem_wdata(mem_wdata)
    );

    read_gather #(
        .WORD_W(WORD_W), .BEATS(BEATS)
    ) gather_i (
        .clk(clk), .rst_n(rst_n), .start(start_rd),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rd_last(rd_last), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !mem_wr && !mem_rd));

    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr || start_rd) |=> busy);
endmodule

// File: tb/seg_word_adapter_tb_top.sv
`timescale 1ns/1ps
module seg_word_adapter_tb_top;
    localparam int MW = 16384;

    typedef struct packed {
        logic [11:0]  pix;
        logic [11:0]  line;
        logic [11:0]  ppl;
        logic [2:0]   words;
        logic [127:0] data;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{12'd3,    12'd2,   12'd10,   3'd4, 128'h44444444_33333333_22222222_11111111},
        '{12'd0,    12'd0,   12'd0,    3'd4, 128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF},
        '{12'd5,    12'd100, 12'd40,   3'd3, 128'hA5A5A5A5_0F0F0F0F_F0F0F0F0_5A5A5A5A},
        '{12'd4095, 12'd0,   12'd1,    3'd1, 128'h11112222_33334444_55556666_77778888},
        '{12'd0,    12'd1,   12'd4095, 3'd0, 128'h0BADCAFE_FEEDFACE_12345678_9ABCDEF0},
        '{12'd7,    12'd1,   12'd9,    3'd2, 128'hFFFFFFFF_EEEEEEEE_DDDDDDDD_CCCCCCCC}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr_en = 1'b0, cmd_rd_en = 1'b0;
    logic [11:0] pix_idx = '0, line_idx = '0, pix_per_line = '0;
    logic [127:0] wr_data = '0;
    logic [2:0] wr_word_cnt = '0;
    logic busy, err, rd_valid, mem_wr, mem_rd;
    logic [127:0] rd_data;
    logic [13:0] mem_addr;
    logic [31:0] mem_wdata;
    logic mem_ready;
    logic [31:0] mem_rdata = '0;
    logic mem_rvalid = 1'b0;

    bit stall = 1'b0;
    logic rdy_tgl = 1'b0;
    logic [31:0] mem_m [0:MW-1];
    logic [13:0] wlog_a [0:255];
    logic [31:0] wlog_d [0:255];
    int wn = 0, rn = 0;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    assign mem_ready = stall ? rdy_tgl : 1'b1;

    seg_word_adapter dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_rd_en(cmd_rd_en),
        .pix_idx(pix_idx), .line_idx(line_idx), .pix_per_line(pix_per_line),
        .wr_data(wr_data), .wr_word_cnt(wr_word_cnt),
        .busy(busy), .err(err), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
    );

    // Word memory model with one-cycle read return, plus a beat log.
    always @(posedge clk) begin
        rdy_tgl <= ~rdy_tgl;
        mem_rvalid <= mem_rd && mem_ready;
        mem_rdata <= mem_m[mem_addr];
        if (mem_wr && mem_ready) begin
            mem_m[mem_addr] <= mem_wdata;
            wlog_a[wn % 256] <= mem_addr;
            wlog_d[wn % 256] <= mem_wdata;
            wn <= wn + 1;
        end
        if (mem_rd && mem_ready) rn <= rn + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input bit rd, input logic [11:0] p, input logic [11:0] l,
                         input logic [11:0] q, input logic [2:0] w, input logic [127:0] d);
        @(negedge clk);
        cmd_wr_en = wr; cmd_rd_en = rd;
        pix_idx = p; line_idx = l; pix_per_line = q;
        wr_word_cnt = w; wr_data = d;
        @(negedge clk);
        cmd_wr_en = 1'b0; cmd_rd_en = 1'b0;
    endtask

    task automatic wait_idle(output logic rv, output logic [127:0] rdat);
        while (busy) @(negedge clk);
        rv = rd_valid;
        rdat = rd_data;
    endtask

    function automatic logic [127:0] masked(input logic [127:0] d, input logic [2:0] w);
        logic [127:0] r;
        int n;
        n = (w == 0 || w > 4) ? 4 : int'(w);
        r = '0;
        for (int k = 0; k < 4; k++)
            if (k < n) r[k*32 +: 32] = d[k*32 +: 32];
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic rv;
        logic [127:0] rdat, expd;
        int w0, r0, seg;

        // R11 reset state
        repeat (3) @(negedge clk);
        chk({busy, err, rd_valid, mem_wr, mem_rd} == 5'b0, "R11 reset outputs",
            128'({busy, err, rd_valid, mem_wr, mem_rd}), 128'd0);
        @(negedge clk); rst_n = 1'b1;

        // Vector table: write, check beats, then read back.
        for (int i = 0; i < NV; i++) begin
            stall = (i % 2) == 1;
            seg = int'(VECS[i].pix) + int'(VECS[i].line) * int'(VECS[i].ppl);
            expd = masked(VECS[i].data, VECS[i].words);
            w0 = wn;
            issue(1'b1, 1'b0, VECS[i].pix, VECS[i].line, VECS[i].ppl, VECS[i].words, VECS[i].data);
            wait_idle(rv, rdat);
            @(negedge clk);
            chk(wn - w0 == 4, "R3 R6 R7 four write beats", 128'(wn - w0), 128'd4);
            for (int k = 0; k < 4; k++) begin
                chk(wlog_a[(w0 + k) % 256] == 14'(seg * 4 + k), "R1 R4 word address",
                    128'(wlog_a[(w0 + k) % 256]), 128'(seg * 4 + k));
                chk(wlog_d[(w0 + k) % 256] == expd[k*32 +: 32], "R2 R3 R6 beat data",
                    128'(wlog_d[(w0 + k) % 256]), 128'(expd[k*32 +: 32]));
            end
            r0 = rn;
            issue(1'b0, 1'b1, VECS[i].pix, VECS[i].line, VECS[i].ppl, 3'd4, '0);
            wait_idle(rv, rdat);
            chk(rv == 1'b1, "R8 read valid pulse", 128'(rv), 128'd1);
            chk(rdat == expd, "R8 assembled read data", rdat, expd);
            @(negedge clk);
            chk(rd_valid == 1'b0, "R8 pulse one cycle", 128'(rd_valid), 128'd0);
            chk(rn - r0 == 4, "R1 four read beats", 128'(rn - r0), 128'd4);
        end
        stall = 1'b0;

        // R5 R7: inputs change and a second command arrives while busy.
        w0 = wn;
        issue(1'b1, 1'b0, 12'd1, 12'd0, 12'd0, 3'd4, 128'h1);
        chk(busy == 1'b1, "R7 busy after accept", 128'(busy), 128'd1);
        cmd_wr_en = 1'b1; pix_idx = 12'd9; wr_data = 128'hFF;
        @(negedge clk); @(negedge clk);
        cmd_wr_en = 1'b0;
        wait_idle(rv, rdat);
        @(negedge clk);
        chk(wn - w0 == 4, "R7 busy command refused", 128'(wn - w0), 128'd4);
        chk(wlog_a[w0 % 256] == 14'd4, "R5 address held", 128'(wlog_a[w0 % 256]), 128'd4);
        chk(wlog_d[w0 % 256] == 32'd1, "R5 data held", 128'(wlog_d[w0 % 256]), 128'd1);

        // R10: both strobes, only the write happens.
        w0 = wn; r0 = rn;
        issue(1'b1, 1'b1, 12'd2, 12'd0, 12'd0, 3'd4, 128'h5);
        wait_idle(rv, rdat);
        @(negedge clk);
        chk(wn - w0 == 4 && rn == r0, "R10 write wins", 128'({wn - w0, rn - r0}), 128'({32'd4, 32'd0}));

        // R9: first index past the end, then a far one.
        w0 = wn; r0 = rn;
        issue(1'b1, 1'b0, 12'd1, 12'd1, 12'd4095, 3'd4, 128'h7);
        chk(err == 1'b1 && busy == 1'b0, "R9 error at 4096", 128'({err, busy}), 128'b10);
        @(negedge clk);
        chk(err == 1'b0, "R9 error one cycle", 128'(err), 128'd0);
        issue(1'b0, 1'b1, 12'd0, 12'd4095, 12'd2, 3'd4, '0);
        chk(err == 1'b1 && busy == 1'b0, "R9 error on read", 128'({err, busy}), 128'b10);
        repeat (3) @(negedge clk);
        chk(wn == w0 && rn == r0, "R9 no beats issued", 128'({wn - w0, rn - r0}), 128'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule